// File: doc/BRIEF.md
# Pin-Addressed Truth-Table Logic Unit

This unit turns a programmable truth table into logic on a digital I/O port. The low `ADDR_W` pin inputs form an address into a table of `2^ADDR_W` words, each `PIN_W` bits wide. Every bit of the word fetched from that address is one output pin's next value. The fetch and the output register are one step, and that step fires only on a prescaled tick. As a result, every output is a Boolean function of the address pins sampled at that tick, and no output ever follows an input combinationally.

If a pin is driven by the table and is also one of the address pins, its pad value feeds back into the next lookup. Such a pin is a state bit: the pad shows the current state and the table word supplies the next one. This lets the unit run finite state machines such as counters.

The table is loaded through a valid/ready write stream. Ready is high only while the unit is stopped. A sender that sees ready low holds its beat (valid, address and data) until ready returns. A beat is taken on any clock edge where valid and ready are both high. Per-pin enables decide which pins the table drives. A static override pair, made of an enable and a value, takes priority over the table on any pin.

Top module: `pinlut_unit`

## Requirements
- R1: While reset is low, the lookup register is zero. So `pin_out` equals `ovr_val` on overridden pins and 0 on all other pins, `pin_oe` equals `lut_en | ovr_en`, and `ld_ready` is high whenever `run` is low.
- R2: `ld_ready` equals the inverse of `run`. A beat with `ld_valid` high and `ld_ready` high writes `ld_data` into table word `ld_addr`. A beat offered while `run` is high has no effect on the table.
- R3: On each tick, the lookup register loads the table word addressed by `pin_in[ADDR_W-1:0]` as sampled at that same clock edge. Bit i of that word is the value the table drives on pin i.
- R4: Count the clock edges at which `run` is high, starting from 1 at the first such edge after `run` was low. A tick happens on every edge whose count is a multiple of `div_val`. A `div_val` of 0 behaves as 1.
- R5: Between ticks, the table-driven values on `pin_out` do not change, whatever the pin inputs do.
- R6: Dropping `run` freezes the outputs at their last values and resets the tick phase, so a later start counts again from 1.
- R7: `pin_oe[i]` is high exactly when `lut_en[i]` or `ovr_en[i]` is high, and it updates in the same cycle as those inputs.
- R8: When `ovr_en[i]` is high, `pin_out[i]` equals `ovr_val[i]` in the same cycle, whatever the table value is. Because the pad carries that value, an overridden address pin also steers the lookup.
- R9: A table-driven pin that is also an address pin acts as a state bit. A table whose word at address a holds a+1 in bits 3:0 when pin 4 is high makes pins 3:0 count up by one on each tick.
- R10: Pins at or above `ADDR_W` are driven only. The table can drive them, but their inputs never take part in the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High while the unit runs; low stops it and blocks nothing but ticks |
| div_val | input | DIV_W | Prescaler divide value (0 acts as 1) |
| ld_valid | input | 1 | Table write beat valid |
| ld_ready | output | 1 | Table write beat accepted (high only while stopped) |
| ld_addr | input | ADDR_W | Table word address of the beat |
| ld_data | input | PIN_W | Table word of the beat |
| lut_en | input | PIN_W | Per-pin enable for table drive |
| ovr_en | input | PIN_W | Per-pin static override enable |
| ovr_val | input | PIN_W | Per-pin static override value |
| pin_in | input | PIN_W | Pad input buffers |
| pin_out | output | PIN_W | Pad output values |
| pin_oe | output | PIN_W | Pad output enables (low means tri-stated) |

## Verification
The assertions check several properties on every cycle. The lookup register never moves without a tick. A table write and a tick never share a cycle. Two ticks come back to back only when the divide value is 1 or less, or when that value has just changed. Every start begins with the prescaler count at zero. Only the bench's scenarios can show the full data path, because it depends on table contents and pad feedback. Those scenarios cover the truth-table contents reaching the pins, a counter built from feedback through the pads, and an override steering the address. They also show that a write offered during a run is dropped, and that the tick phase restarts after a stop. A behavioural reference of pads, table and tick count is compared against the outputs every cycle.

// File: rtl/pinlut_pkg.sv
package pinlut_pkg;
  // Effective last count of a prescale period: a divide value of 0 or 1 yields 0.
  function automatic logic [15:0] period_last(input logic [15:0] div);
    return (div == 16'd0) ? 16'd0 : div - 16'd1;
  endfunction
endpackage

// File: rtl/pinlut_prescaler.sv
module pinlut_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (div_val == '0) ? '0 : div_val - ONE;
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + ONE;
  end

  // R4 / R6: every start is phase-aligned, counting from zero.
  assert_start_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));

  // R4: with a period longer than one cycle, ticks are never adjacent.
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (last != '0)) |=> (!tick || !$stable(div_val)));
endmodule

// File: rtl/pinlut_table.sv
module pinlut_table #(
  parameter int ADDR_W = 10,
  parameter int PIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [PIN_W-1:0]  ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PIN_W-1:0]  look
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [PIN_W-1:0] mem [0:DEPTH-1];
  logic             wr_fire;

  assign ld_ready = !run;
  assign wr_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[ld_addr] <= ld_data;
  end

  // Synchronous read doubles as the output register: enabled only on a tick.
  always_ff @(posedge clk) begin
    if (!rst_n)     look <= '0;
    else if (tick)  look <= mem[rd_addr];
  end

  // R5: lookup register holds between ticks.
  assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(look));

  // R2: a table write never coincides with a running tick.
  assert_no_write_while_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !tick);
endmodule

// File: rtl/pinlut_drive.sv
module pinlut_drive #(
  parameter int PIN_W = 16
) (
  input  logic [PIN_W-1:0] look,
  input  logic [PIN_W-1:0] lut_en,
  input  logic [PIN_W-1:0] ovr_en,
  input  logic [PIN_W-1:0] ovr_val,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    // R8: static override wins over the table value.
    assign pin_out[i] = ovr_en[i] ? ovr_val[i] : look[i];
    // R7: pad enabled by either source.
    assign pin_oe[i]  = ovr_en[i] | lut_en[i];
  end
endmodule

// File: rtl/pinlut_unit.sv
module pinlut_unit #(
  parameter int ADDR_W = 10,
  parameter int PIN_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [PIN_W-1:0]  ld_data,
  input  logic [PIN_W-1:0]  lut_en,
  input  logic [PIN_W-1:0]  ovr_en,
  input  logic [PIN_W-1:0]  ovr_val,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);
  logic              tick;
  logic [ADDR_W-1:0] rd_addr;
  logic [PIN_W-1:0]  look;

  // R10: only the low ADDR_W pads form the address.
  assign rd_addr = pin_in[ADDR_W-1:0];

  pinlut_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val), .tick(tick)
  );

  pinlut_table #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_table (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .look(look)
  );

  pinlut_drive #(.PIN_W(PIN_W)) u_drive (
    .look(look), .lut_en(lut_en), .ovr_en(ovr_en), .ovr_val(ovr_val),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: tb/pinlut_unit_test.sv
module pinlut_unit_test;
  logic        clk = 1'b0;
  logic        rst_n, run, ld_valid;
  logic [15:0] div_val, ld_data, lut_en, ovr_en, ovr_val, ext_in;
  logic [9:0]  ld_addr;
  logic        ld_ready;
  logic [15:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  // Pad model: an enabled pad reads back its own drive.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  pinlut_unit uut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .lut_en(lut_en), .ovr_en(ovr_en), .ovr_val(ovr_val),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [15:0] tbl(input logic [9:0] a);
    logic [15:0] w;
    w[3:0]   = a[4] ? a[3:0] + 4'd1 : a[3:0];
    w[9:4]   = ~a[9:4];
    w[10]    = &a[7:5];
    w[11]    = ^a[9:4];
    w[15:12] = a[9:6] ^ a[3:0];
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  // Behavioural reference
  logic [15:0] m_mem [0:1023];
  logic [15:0] m_look;
  int          m_edges;
  logic [15:0] m_out, m_oe;
  assign m_out = (ovr_en & ovr_val) | (~ovr_en & m_look);
  assign m_oe  = ovr_en | lut_en;

  always @(posedge clk) begin
    logic [15:0] pad;
    int d;
    if (!rst_n) begin
      m_look  = '0;
      m_edges = 0;
    end else begin
      pad = (m_oe & m_out) | (~m_oe & ext_in);
      if (run) begin
        m_edges++;
        d = (div_val == 0) ? 1 : int'(div_val);
        if (m_edges % d == 0) m_look = m_mem[pad[9:0]];
      end else begin
        m_edges = 0;
      end
      if (ld_valid && !run) m_mem[ld_addr] = ld_data;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(ld_ready == !run, "R2 ready", {15'd0, ld_ready}, {15'd0, !run});
      chk(pin_oe == m_oe, "R7 oe", pin_oe, m_oe);
      chk((pin_out & ~ovr_en) == (m_out & ~ovr_en), "R3 lookup", pin_out, m_out);
      chk((pin_out & ovr_en) == (ovr_val & ovr_en), "R8 override", pin_out, m_out);
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; run = 0; div_val = 16'd1; ld_valid = 0; ld_addr = '0; ld_data = '0;
    lut_en = 16'hFC0F; ovr_en = '0; ovr_val = '0; ext_in = '0;
    step(3);
    @(negedge clk);
    chk(pin_oe == 16'hFC0F, "R1 oe in reset", pin_oe, 16'hFC0F);
    chk(pin_out == 16'h0000, "R1 out in reset", pin_out, 16'h0000);
    chk(ld_ready == 1'b1, "R1 ready in reset", {15'd0, ld_ready}, 16'd1);
    step(1);
    rst_n = 1;
    cmp_on = 1;
    for (int a = 0; a < 1024; a++) begin
      ld_valid = 1; ld_addr = 10'(a); ld_data = tbl(10'(a));
      step(1);
    end
    ld_valid = 0;

    // R9 counter through pad feedback, div 1; write attempt while running (R2)
    ext_in = 16'h0010; run = 1;
    ld_valid = 1; ld_addr = 10'h3FF; ld_data = 16'h0000;
    step(5);
    @(negedge clk);
    chk(pin_out[3:0] == 4'd5, "R9 counter", {12'd0, pin_out[3:0]}, 16'd5);
    chk(ld_ready == 1'b0, "R2 blocked", {15'd0, ld_ready}, 16'd0);
    step(1);
    ld_valid = 0;
    @(negedge clk);
    v = pin_out;
    // R6 stop freezes
    step(1);
    run = 0;
    step(1);
    @(negedge clk);
    v = pin_out;
    step(3);
    @(negedge clk);
    chk(pin_out == v, "R6 frozen", pin_out, v);
    chk(ld_ready == 1'b1, "R6 ready", {15'd0, ld_ready}, 16'd1);

    // R4 / R5 div 3 phase
    step(1);
    div_val = 16'd3; run = 1;
    step(2);
    @(negedge clk);
    chk(pin_out == v, "R5 hold", pin_out, v);
    step(1);
    @(negedge clk);
    chk(pin_out[3:0] == v[3:0] + 4'd1, "R4 tick", {12'd0, pin_out[3:0]}, {12'd0, v[3:0] + 4'd1});
    v = pin_out;

    // R3 / R10 AND of pins 7:5 on pin 10, counter disabled
    ext_in = 16'h00E0;
    step(3);
    @(negedge clk);
    chk(pin_out[10] == 1'b1, "R10 and", {15'd0, pin_out[10]}, 16'd1);
    chk(pin_out[3:0] == v[3:0], "R3 held count", {12'd0, pin_out[3:0]}, {12'd0, v[3:0]});

    // R7 / R8 same-cycle effect
    step(1);
    ovr_en = 16'h0002; ovr_val = 16'h0000; lut_en = 16'hFC0E;
    @(negedge clk);
    chk(pin_oe[0] == 1'b0, "R7 disabled", {15'd0, pin_oe[0]}, 16'd0);
    chk(pin_oe[1] == 1'b1, "R7 enabled", {15'd0, pin_oe[1]}, 16'd1);
    chk(pin_out[1] == 1'b0, "R8 value", {15'd0, pin_out[1]}, 16'd0);

    // R2 ignored write; R4 div 0 acts as 1; R8 override steers address
    step(1);
    run = 0; div_val = 16'd0; lut_en = 16'hFC0F;
    ovr_en = 16'h000F; ovr_val = 16'h000F; ext_in = 16'h03F0;
    step(2);
    run = 1;
    step(1);
    @(negedge clk);
    chk(pin_out[10] == 1'b1, "R2 ignored write", {15'd0, pin_out[10]}, 16'd1);
    chk(pin_out[15:12] == 4'h0, "R4 div0 tick", {12'd0, pin_out[15:12]}, 16'd0);
    step(2);
    cmp_on = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule